// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic stage of a small 8-bit accumulator processor that can also treat its two accumulators as one 16-bit register. Each cycle it takes an operation code, two byte operands, a 16-bit second operand and the current flag byte. It returns the result and the next flag byte. Each operation has its own rule for which flags it computes, forces or keeps. A separate condition evaluator turns the incoming flag byte and a 4-bit test code into a take/skip decision for conditional branches.

The 16-bit accumulator pair is formed as `{a_i, b_i}`, with `a_i` as the high byte. Byte results appear in `res_o[7:0]` with `res_o[15:8]` zero. By default the outputs are registered, so a result appears one clock after its operands. Setting `OUT_REG` to 0 makes the whole block combinational.

Top module: `acc_alu_cc`

## Requirements
- R1: Flag byte layout is H=bit 5, I=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. I and bits 7:6 are always copied from `cc_i`. Byte operations return their result in `res_o[7:0]` with the upper byte zero.
- R2: ADD (code 0) and ADC (code 1, adds C as carry in) return A+B. H is the carry from bit 3 into bit 4. V is set when A and B have the same sign and the result sign differs. C is the carry out. N and Z follow the result.
- R3: SUB (2), SBC (3, subtracts C as borrow), CMP (4) and NEG (10, 0−A) compute a difference. C means a borrow occurred. V is set when the operands differ in sign and the result sign differs from the minuend. H is kept. CMP returns A unchanged and sets N and Z from the difference.
- R4: AND (5), OR (6), XOR (7) and PASS (8, returns B) set N and Z from the result, clear V and keep C and H.
- R5: COM (9) returns ~A with V=0 and C=1. CLR (13) returns 0 with N=0, Z=1, V=0, C=0. TST (14) returns A with V=0 and C=0, and N and Z from A.
- R6: INC (11) and DEC (12) return A±1. V is set exactly for 0x7F→0x80 and 0x80→0x7F respectively. C and H are kept.
- R7: LSR (15), ASL (16), ASR (17), ROL (18) and ROR (19) move the shifted-out bit into C. LSR fills with 0 and ASR repeats bit 7. ROL and ROR fill from the incoming C. N and Z follow the result (so N=0 after LSR), and V = N xor C.
- R8: DAA (20) adds 0x06 when H=1 or the low nibble exceeds 9. It adds 0x60 when C=1, the high nibble exceeds 9, or the high nibble exceeds 8 while the low nibble exceeds 9. C is set when the 0x60 term applies and kept set otherwise, V is cleared, and N and Z follow the result.
- R9: MUL (21) returns the unsigned 16-bit product A×B. C is set to product bit 7 and every other flag is kept.
- R10: ADDW (22) and SUBW (23) return {A,B} + W and {A,B} − W. N, Z, V and C are computed over all 16 bits (C is the borrow for SUBW) and H is kept.
- R11: INCW (24) and DECW (25) return W+1 and W−1 and change only Z, which is set when all 16 result bits are zero.
- R12: `take_o` depends only on `cc_i` and `cond_i`, never on the op code. The codes are: 0 always, 1 never, 2 C|Z clear, 3 C|Z set, 4 C clear, 5 C set, 6 Z clear, 7 Z set, 8 V clear, 9 V set, 10 N clear, 11 N set, 12 N^V clear, 13 N^V set, 14 Z|(N^V) clear, 15 Z|(N^V) set. Each odd code is the complement of the even code below it.
- R13: Op codes 26 to 31 return 0 and leave the flag byte unchanged.
- R14: With `OUT_REG`=1, `res_o`, `cc_o` and `take_o` change one clock after their inputs, and they read 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Byte operand A, high byte of the pair |
| b_i | input | 8 | Byte operand B, low byte of the pair |
| w_i | input | 16 | 16-bit second operand, or the operand of INCW/DECW |
| cc_i | input | 8 | Current flag byte |
| cond_i | input | 4 | Branch test code |
| res_o | output | 16 | Result |
| cc_o | output | 8 | Next flag byte |
| take_o | output | 1 | Branch test outcome |

## Verification
The hardest combinations to reach are the decimal adjust corrections that depend on the incoming H and C flags together with nibble values, and the flag-keeping rules that are visible only when the incoming flags already hold an unusual pattern. Because `cc_i` is a direct port, the stimulus sweeps every operation over all pairs of the edge values 0x00, 0x7F, 0x80 and 0xFF under two opposite flag bytes. Random operands are then applied with a random incoming flag byte, so that kept flags, carry-in and half-carry inputs appear in both polarities. The branch evaluator is swept over all 16 codes and all 16 NZVC patterns while the op code varies.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CMP  = 5'd4,
      OP_AND  = 5'd5,
      OP_OR   = 5'd6,
      OP_XOR  = 5'd7,
      OP_PASS = 5'd8,
      OP_COM  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_CLR  = 5'd13,
      OP_TST  = 5'd14,
      OP_LSR  = 5'd15,
      OP_ASL  = 5'd16,
      OP_ASR  = 5'd17,
      OP_ROL  = 5'd18,
      OP_ROR  = 5'd19,
      OP_DAA  = 5'd20,
      OP_MUL  = 5'd21,
      OP_ADDW = 5'd22,
      OP_SUBW = 5'd23,
      OP_INCW = 5'd24,
      OP_DECW = 5'd25
   } alu_op_e;

   localparam int OP_LAST = 25;

   localparam int CC_C = 0;
   localparam int CC_V = 1;
   localparam int CC_Z = 2;
   localparam int CC_N = 3;
   localparam int CC_I = 4;
   localparam int CC_H = 5;

   typedef enum logic [2:0] {
      SH_LSR  = 3'd0,
      SH_ASL  = 3'd1,
      SH_ASR  = 3'd2,
      SH_ROL  = 3'd3,
      SH_ROR  = 3'd4,
      SH_NONE = 3'd7
   } shift_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [W-1:0] r_o,
   output logic         c_o,
   output logic         v_o
);
   logic [W-1:0] y_eff;
   logic         cin_eff;
   logic [W:0]   sum;

   // subtraction is x + ~y + ~borrow; the carry out inverts into a borrow
   assign y_eff   = sub_i ? ~y_i : y_i;
   assign cin_eff = sub_i ? ~cin_i : cin_i;
   assign sum     = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, cin_eff};
   assign r_o     = sum[W-1:0];
   assign c_o     = sum[W] ^ sub_i;
   assign v_o     = (x_i[W-1] == y_eff[W-1]) && (r_o[W-1] != x_i[W-1]);

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic         cin_i,
   input  shift_e       mode_i,
   output logic [W-1:0] r_o,
   output logic         c_o
);
   always_comb begin
      r_o = a_i;
      c_o = cin_i;
      case (mode_i)
         SH_LSR: begin r_o = {1'b0, a_i[W-1:1]};     c_o = a_i[0];   end
         SH_ASL: begin r_o = {a_i[W-2:0], 1'b0};     c_o = a_i[W-1]; end
         SH_ASR: begin r_o = {a_i[W-1], a_i[W-1:1]}; c_o = a_i[0];   end
         SH_ROL: begin r_o = {a_i[W-2:0], cin_i};    c_o = a_i[W-1]; end
         SH_ROR: begin r_o = {cin_i, a_i[W-1:1]};    c_o = a_i[0];   end
         default: begin r_o = a_i; c_o = cin_i; end
      endcase
   end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
   parameter int W   = 8,
   parameter int NIB = 4
) (
   input  logic [W-1:0] a_i,
   input  logic         h_i,
   input  logic         c_i,
   output logic [W-1:0] r_o,
   output logic         c_o
);
   localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
   localparam logic [NIB-1:0] FIX       = NIB'(6);

   logic [NIB-1:0] lo;
   logic [NIB-1:0] hi;
   logic           fix_lo;
   logic           fix_hi;

   assign lo     = a_i[NIB-1:0];
   assign hi     = a_i[2*NIB-1:NIB];
   assign fix_lo = h_i || (lo > DIGIT_MAX);
   assign fix_hi = c_i || (hi > DIGIT_MAX) || ((hi > (DIGIT_MAX - NIB'(1))) && (lo > DIGIT_MAX));
   assign r_o    = a_i + {(fix_hi ? FIX : '0), (fix_lo ? FIX : '0)};
   assign c_o    = fix_hi;

endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
   import acc_alu_pkg::*;
#(
   parameter int CCW   = 8,
   parameter int CONDW = 4
) (
   input  logic [CCW-1:0]   cc_i,
   input  logic [CONDW-1:0] cond_i,
   output logic             take_o
);
   logic n, z, v, c;
   logic base;

   assign n = cc_i[CC_N];
   assign z = cc_i[CC_Z];
   assign v = cc_i[CC_V];
   assign c = cc_i[CC_C];

   // even code is the base test, odd code its complement
   always_comb begin
      case (cond_i[CONDW-1:1])
         3'd0:    base = 1'b1;
         3'd1:    base = ~(c | z);
         3'd2:    base = ~c;
         3'd3:    base = ~z;
         3'd4:    base = ~v;
         3'd5:    base = ~n;
         3'd6:    base = ~(n ^ v);
         default: base = ~(z | (n ^ v));
      endcase
   end

   assign take_o = base ^ cond_i[0];

endmodule

// File: rtl/acc_alu_cc.sv
module acc_alu_cc
   import acc_alu_pkg::*;
#(
   parameter int DW      = 8,
   parameter int CCW     = 8,
   parameter int CONDW   = 4,
   parameter int OPW     = 5,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPW-1:0]    op_i,
   input  logic [DW-1:0]     a_i,
   input  logic [DW-1:0]     b_i,
   input  logic [2*DW-1:0]   w_i,
   input  logic [CCW-1:0]    cc_i,
   input  logic [CONDW-1:0]  cond_i,
   output logic [2*DW-1:0]   res_o,
   output logic [CCW-1:0]    cc_o,
   output logic              take_o
);
   localparam int WW  = 2 * DW;
   localparam int NIB = 4;

   if (DW != 8) begin : g_bad_dw
      $error("acc_alu_cc: DW must be 8");
   end
   if (CCW != 8) begin : g_bad_ccw
      $error("acc_alu_cc: CCW must be 8");
   end
   if (CONDW != 4) begin : g_bad_condw
      $error("acc_alu_cc: CONDW must be 4");
   end
   if (OPW != 5) begin : g_bad_opw
      $error("acc_alu_cc: OPW must be 5");
   end

   // ---------------- byte adder operand selection ----------------
   logic [DW-1:0] add_x, add_y, add_r;
   logic          add_sub, add_cin, add_c, add_v;
   logic          half_c;

   always_comb begin
      add_x   = a_i;
      add_y   = b_i;
      add_sub = 1'b0;
      add_cin = 1'b0;
      case (op_i)
         OP_ADC:         add_cin = cc_i[CC_C];
         OP_SUB, OP_CMP: add_sub = 1'b1;
         OP_SBC: begin add_sub = 1'b1; add_cin = cc_i[CC_C]; end
         OP_NEG: begin add_x = '0; add_y = a_i; add_sub = 1'b1; end
         OP_INC:         add_y = DW'(1);
         OP_DEC: begin add_y = DW'(1); add_sub = 1'b1; end
         default: ;
      endcase
   end

   acc_alu_addsub #(.W(DW)) u_add8 (
      .x_i   (add_x),
      .y_i   (add_y),
      .sub_i (add_sub),
      .cin_i (add_cin),
      .r_o   (add_r),
      .c_o   (add_c),
      .v_o   (add_v)
   );

   // carry into bit NIB recovered from the operand and sum bits
   assign half_c = add_x[NIB] ^ add_y[NIB] ^ add_r[NIB];

   // ---------------- 16-bit adder ----------------
   logic [WW-1:0] wx, wy, w_r;
   logic          w_sub, w_c, w_v;
   logic          w_on_index;

   assign w_on_index = (op_i == OP_INCW) || (op_i == OP_DECW);
   assign wx         = w_on_index ? w_i : {a_i, b_i};
   assign wy         = w_on_index ? WW'(1) : w_i;
   assign w_sub      = (op_i == OP_SUBW) || (op_i == OP_DECW);

   acc_alu_addsub #(.W(WW)) u_add16 (
      .x_i   (wx),
      .y_i   (wy),
      .sub_i (w_sub),
      .cin_i (1'b0),
      .r_o   (w_r),
      .c_o   (w_c),
      .v_o   (w_v)
   );

   // ---------------- shifter, decimal adjust, multiplier ----------------
   shift_e        sh_mode;
   logic [DW-1:0] sh_r;
   logic          sh_c;

   always_comb begin
      case (op_i)
         OP_LSR:  sh_mode = SH_LSR;
         OP_ASL:  sh_mode = SH_ASL;
         OP_ASR:  sh_mode = SH_ASR;
         OP_ROL:  sh_mode = SH_ROL;
         OP_ROR:  sh_mode = SH_ROR;
         default: sh_mode = SH_NONE;
      endcase
   end

   acc_alu_shift #(.W(DW)) u_shift (
      .a_i    (a_i),
      .cin_i  (cc_i[CC_C]),
      .mode_i (sh_mode),
      .r_o    (sh_r),
      .c_o    (sh_c)
   );

   logic [DW-1:0] dj_r;
   logic          dj_c;

   acc_alu_decadj #(.W(DW), .NIB(NIB)) u_decadj (
      .a_i (a_i),
      .h_i (cc_i[CC_H]),
      .c_i (cc_i[CC_C]),
      .r_o (dj_r),
      .c_o (dj_c)
   );

   logic [WW-1:0] prod;
   assign prod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};

   logic take_c;

   acc_alu_cond #(.CCW(CCW), .CONDW(CONDW)) u_cond (
      .cc_i   (cc_i),
      .cond_i (cond_i),
      .take_o (take_c)
   );

   // ---------------- result and flag selection ----------------
   logic [WW-1:0]  res_c;
   logic [CCW-1:0] cc_c;
   logic [DW-1:0]  r8;
   logic           byte_op;

   always_comb begin
      cc_c    = cc_i;
      r8      = '0;
      byte_op = 1'b1;
      res_c   = '0;
      case (op_i)
         OP_ADD, OP_ADC: begin
            r8         = add_r;
            cc_c[CC_H] = half_c;
            cc_c[CC_V] = add_v;
            cc_c[CC_C] = add_c;
         end
         OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
            r8         = add_r;
            cc_c[CC_V] = add_v;
            cc_c[CC_C] = add_c;
         end
         OP_INC, OP_DEC: begin
            r8         = add_r;
            cc_c[CC_V] = add_v;
         end
         OP_AND, OP_OR, OP_XOR, OP_PASS: begin
            case (op_i)
               OP_AND:  r8 = a_i & b_i;
               OP_OR:   r8 = a_i | b_i;
               OP_XOR:  r8 = a_i ^ b_i;
               default: r8 = b_i;
            endcase
            cc_c[CC_V] = 1'b0;
         end
         OP_COM: begin
            r8         = ~a_i;
            cc_c[CC_V] = 1'b0;
            cc_c[CC_C] = 1'b1;
         end
         OP_CLR: begin
            r8         = '0;
            cc_c[CC_V] = 1'b0;
            cc_c[CC_C] = 1'b0;
         end
         OP_TST: begin
            r8         = a_i;
            cc_c[CC_V] = 1'b0;
            cc_c[CC_C] = 1'b0;
         end
         OP_LSR, OP_ASL, OP_ASR, OP_ROL, OP_ROR: begin
            r8         = sh_r;
            cc_c[CC_C] = sh_c;
            cc_c[CC_V] = sh_r[DW-1] ^ sh_c;
         end
         OP_DAA: begin
            r8         = dj_r;
            cc_c[CC_V] = 1'b0;
            cc_c[CC_C] = dj_c;
         end
         default: byte_op = 1'b0;
      endcase

      if (byte_op) begin
         cc_c[CC_N] = r8[DW-1];
         cc_c[CC_Z] = (r8 == '0);
         res_c      = (op_i == OP_CMP) ? {{DW{1'b0}}, a_i} : {{DW{1'b0}}, r8};
      end else begin
         case (op_i)
            OP_MUL: begin
               res_c      = prod;
               cc_c[CC_C] = prod[DW-1];
            end
            OP_ADDW, OP_SUBW: begin
               res_c      = w_r;
               cc_c[CC_N] = w_r[WW-1];
               cc_c[CC_Z] = (w_r == '0);
               cc_c[CC_V] = w_v;
               cc_c[CC_C] = w_c;
            end
            OP_INCW, OP_DECW: begin
               res_c      = w_r;
               cc_c[CC_Z] = (w_r == '0);
            end
            default: begin
               res_c = '0;
               cc_c  = cc_i;
            end
         endcase
      end
   end

   // ---------------- output stage variant ----------------
   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o  <= '0;
            cc_o   <= '0;
            take_o <= 1'b0;
         end else begin
            res_o  <= res_c;
            cc_o   <= cc_c;
            take_o <= take_c;
         end
      end
   end else begin : g_out_comb
      assign res_o  = res_c;
      assign cc_o   = cc_c;
      assign take_o = take_c;
   end

endmodule

// File: rtl/acc_alu_cc_chk.sv
module acc_alu_cc_chk
   import acc_alu_pkg::*;
#(
   parameter int DW      = 8,
   parameter int CCW     = 8,
   parameter int CONDW   = 4,
   parameter int OPW     = 5,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OPW-1:0]    op_i,
   input logic [DW-1:0]     a_i,
   input logic [DW-1:0]     b_i,
   input logic [CCW-1:0]    cc_i,
   input logic [CONDW-1:0]  cond_i,
   input logic [2*DW-1:0]   res_o,
   input logic [CCW-1:0]    cc_o,
   input logic              take_o
);
   logic [OPW-1:0]   p_op;
   logic [DW-1:0]    p_a;
   logic [DW-1:0]    p_b;
   logic [CCW-1:0]   p_cc;
   logic [CONDW-1:0] p_cond;
   logic             p_vld;

   // align the inputs with the outputs they produced
   if (OUT_REG) begin : g_align_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_op   <= '0;
            p_a    <= '0;
            p_b    <= '0;
            p_cc   <= '0;
            p_cond <= '0;
            p_vld  <= 1'b0;
         end else begin
            p_op   <= op_i;
            p_a    <= a_i;
            p_b    <= b_i;
            p_cc   <= cc_i;
            p_cond <= cond_i;
            p_vld  <= 1'b1;
         end
      end
   end else begin : g_align_comb
      assign p_op   = op_i;
      assign p_a    = a_i;
      assign p_b    = b_i;
      assign p_cc   = cc_i;
      assign p_cond = cond_i;
      assign p_vld  = rst_n;
   end

   // R1
   i_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_vld |-> (cc_o[CC_I] == p_cc[CC_I]) && (cc_o[CCW-1:CC_H+1] == p_cc[CCW-1:CC_H+1]));

   // R4
   logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && (p_op == OP_AND || p_op == OP_OR || p_op == OP_XOR || p_op == OP_PASS))
      |-> !cc_o[CC_V] && (cc_o[CC_C] == p_cc[CC_C]) && (cc_o[CC_Z] == (res_o[DW-1:0] == '0)));

   // R5
   clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_op == OP_CLR) |-> (res_o == '0) && (cc_o[CC_N:CC_C] == 4'b0100));

   // R5
   complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_op == OP_COM) |-> cc_o[CC_C] && !cc_o[CC_V] && (res_o[DW-1:0] == ~p_a));

   // R7
   lsr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_op == OP_LSR) |-> !cc_o[CC_N] && (cc_o[CC_C] == p_a[0]));

   // R9
   mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_op == OP_MUL) |-> (cc_o[CCW-1:1] == p_cc[CCW-1:1]) && (cc_o[CC_C] == res_o[DW-1]));

   // R10
   wide_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && (p_op == OP_ADDW || p_op == OP_SUBW)) |-> (cc_o[CC_H] == p_cc[CC_H]));

   // R11
   index_zonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && (p_op == OP_INCW || p_op == OP_DECW))
      |-> ({cc_o[CCW-1:CC_N], cc_o[CC_V:CC_C]} == {p_cc[CCW-1:CC_N], p_cc[CC_V:CC_C]})
          && (cc_o[CC_Z] == (res_o == '0)));

   // R12
   branch_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_cond[CONDW-1:1] == '0) |-> (take_o == ~p_cond[0]));

   // R13
   unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_op > OPW'(OP_LAST)) |-> (res_o == '0) && (cc_o == p_cc));

   // R3
   compare_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld && p_op == OP_CMP) |-> (res_o[DW-1:0] == p_a) && (cc_o[CC_H] == p_cc[CC_H]));

endmodule

bind acc_alu_cc acc_alu_cc_chk #(
   .DW      (DW),
   .CCW     (CCW),
   .CONDW   (CONDW),
   .OPW     (OPW),
   .OUT_REG (OUT_REG)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .op_i   (op_i),
   .a_i    (a_i),
   .b_i    (b_i),
   .cc_i   (cc_i),
   .cond_i (cond_i),
   .res_o  (res_o),
   .cc_o   (cc_o),
   .take_o (take_o)
);

// File: tb/acc_alu_cc_tb.sv
module acc_alu_cc_tb_top;
   import acc_alu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_i = '0;
   logic [7:0]  a_i = '0;
   logic [7:0]  b_i = '0;
   logic [15:0] w_i = '0;
   logic [7:0]  cc_i = '0;
   logic [3:0]  cond_i = '0;
   logic [15:0] res_o;
   logic [7:0]  cc_o;
   logic        take_o;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   acc_alu_cc dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (op_i),
      .a_i    (a_i),
      .b_i    (b_i),
      .w_i    (w_i),
      .cc_i   (cc_i),
      .cond_i (cond_i),
      .res_o  (res_o),
      .cc_o   (cc_o),
      .take_o (take_o)
   );

   typedef struct packed {
      logic [4:0]  op;
      logic [7:0]  a;
      logic [7:0]  b;
      logic [15:0] w;
      logic [7:0]  cc;
      logic [15:0] er;
      logic [7:0]  ec;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VECS [NV] = '{
      '{OP_ADD,  8'h7F, 8'h01, 16'h0000, 8'hC0, 16'h0080, 8'hEA},
      '{OP_ADC,  8'hFF, 8'h00, 16'h0000, 8'hC1, 16'h0000, 8'hE5},
      '{OP_SUB,  8'h80, 8'h01, 16'h0000, 8'hC0, 16'h007F, 8'hC2},
      '{OP_SBC,  8'h00, 8'h00, 16'h0000, 8'hE1, 16'h00FF, 8'hE9},
      '{OP_CMP,  8'h10, 8'h10, 16'h0000, 8'hC0, 16'h0010, 8'hC4},
      '{OP_AND,  8'hF0, 8'h3C, 16'h0000, 8'hC3, 16'h0030, 8'hC1},
      '{OP_OR,   8'h80, 8'h01, 16'h0000, 8'hC0, 16'h0081, 8'hC8},
      '{OP_XOR,  8'hAA, 8'hAA, 16'h0000, 8'hC2, 16'h0000, 8'hC4},
      '{OP_PASS, 8'h99, 8'h00, 16'h0000, 8'hC2, 16'h0000, 8'hC4},
      '{OP_COM,  8'h00, 8'h00, 16'h0000, 8'hC0, 16'h00FF, 8'hC9},
      '{OP_NEG,  8'h80, 8'h00, 16'h0000, 8'hC0, 16'h0080, 8'hCB},
      '{OP_INC,  8'h7F, 8'h00, 16'h0000, 8'hC1, 16'h0080, 8'hCB},
      '{OP_DEC,  8'h00, 8'h00, 16'h0000, 8'hC0, 16'h00FF, 8'hC8},
      '{OP_CLR,  8'h55, 8'h00, 16'h0000, 8'hEF, 16'h0000, 8'hE4},
      '{OP_TST,  8'h80, 8'h00, 16'h0000, 8'hC3, 16'h0080, 8'hC8},
      '{OP_LSR,  8'h01, 8'h00, 16'h0000, 8'hC8, 16'h0000, 8'hC7},
      '{OP_ASL,  8'h40, 8'h00, 16'h0000, 8'hC0, 16'h0080, 8'hCA},
      '{OP_ASR,  8'h81, 8'h00, 16'h0000, 8'hC0, 16'h00C0, 8'hC9},
      '{OP_ROL,  8'h80, 8'h00, 16'h0000, 8'hC1, 16'h0001, 8'hC3},
      '{OP_ROR,  8'h01, 8'h00, 16'h0000, 8'hC1, 16'h0080, 8'hC9},
      '{OP_DAA,  8'h9A, 8'h00, 16'h0000, 8'hC0, 16'h0000, 8'hC5},
      '{OP_DAA,  8'h12, 8'h00, 16'h0000, 8'hE0, 16'h0018, 8'hE0},
      '{OP_MUL,  8'hFF, 8'hFF, 16'h0000, 8'hCE, 16'hFE01, 8'hCE},
      '{OP_MUL,  8'h10, 8'h08, 16'h0000, 8'hC0, 16'h0080, 8'hC1},
      '{OP_ADDW, 8'h7F, 8'hFF, 16'h0001, 8'hE0, 16'h8000, 8'hEA},
      '{OP_SUBW, 8'h00, 8'h00, 16'h0001, 8'hC0, 16'hFFFF, 8'hC9},
      '{OP_INCW, 8'h00, 8'h00, 16'hFFFF, 8'hCB, 16'h0000, 8'hCF},
      '{OP_DECW, 8'h00, 8'h00, 16'h0002, 8'hC4, 16'h0001, 8'hC0},
      '{5'd31,   8'h12, 8'h34, 16'h0000, 8'hD5, 16'h0000, 8'hD5},
      '{5'd26,   8'hFF, 8'hFF, 16'hFFFF, 8'h2A, 16'h0000, 8'h2A}
   };

   function automatic string tag_of(logic [4:0] op);
      case (op)
         5'd0, 5'd1:                 return "R2";
         5'd2, 5'd3, 5'd4, 5'd10:    return "R3";
         5'd5, 5'd6, 5'd7, 5'd8:     return "R4";
         5'd9, 5'd13, 5'd14:         return "R5";
         5'd11, 5'd12:               return "R6";
         5'd15, 5'd16, 5'd17, 5'd18, 5'd19: return "R7";
         5'd20:                      return "R8";
         5'd21:                      return "R9";
         5'd22, 5'd23:               return "R10";
         5'd24, 5'd25:               return "R11";
         default:                    return "R13";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent reference built from the requirement text
   task automatic ref_model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                            input logic [15:0] w, input logic [7:0] cc,
                            output logic [15:0] er, output logic [7:0] ec);
      logic [7:0]  r;
      logic [15:0] r16;
      logic        h, n, z, v, c;
      int          t, ci, lo, hi, adj;
      logic        fh;
      h = cc[5]; n = cc[3]; z = cc[2]; v = cc[1]; c = cc[0];
      ci = int'(cc[0]);
      er = '0;
      r  = '0;
      if (op <= 5'd20) begin
         case (op)
            5'd0, 5'd1: begin
               t = int'(a) + int'(b) + ((op == 5'd1) ? ci : 0);
               r = 8'(t);
               h = ((int'(a) % 16) + (int'(b) % 16) + ((op == 5'd1) ? ci : 0)) > 15;
               v = (a[7] == b[7]) && (r[7] != a[7]);
               c = (t > 255);
            end
            5'd2, 5'd3, 5'd4: begin
               t = int'(a) - int'(b) - ((op == 5'd3) ? ci : 0);
               r = 8'(t);
               v = (a[7] != b[7]) && (r[7] != a[7]);
               c = (t < 0);
            end
            5'd10: begin r = 8'(0 - int'(a)); v = (a == 8'h80); c = (a != 8'h00); end
            5'd11: begin r = a + 8'd1; v = (a == 8'h7F); end
            5'd12: begin r = a - 8'd1; v = (a == 8'h80); end
            5'd5:  begin r = a & b; v = 1'b0; end
            5'd6:  begin r = a | b; v = 1'b0; end
            5'd7:  begin r = a ^ b; v = 1'b0; end
            5'd8:  begin r = b;     v = 1'b0; end
            5'd9:  begin r = ~a;    v = 1'b0; c = 1'b1; end
            5'd13: begin r = 8'h00; v = 1'b0; c = 1'b0; end
            5'd14: begin r = a;     v = 1'b0; c = 1'b0; end
            5'd15: begin r = a >> 1;           c = a[0]; end
            5'd16: begin r = a << 1;           c = a[7]; end
            5'd17: begin r = {a[7], a[7:1]};   c = a[0]; end
            5'd18: begin r = {a[6:0], cc[0]};  c = a[7]; end
            5'd19: begin r = {cc[0], a[7:1]};  c = a[0]; end
            default: begin
               lo  = int'(a) % 16;
               hi  = int'(a) / 16;
               fh  = cc[0] || (hi > 9) || ((hi > 8) && (lo > 9));
               adj = ((cc[5] || (lo > 9)) ? 6 : 0) + (fh ? 96 : 0);
               r   = 8'(int'(a) + adj);
               c   = fh;
               v   = 1'b0;
            end
         endcase
         n = r[7];
         z = (r == 8'h00);
         if (op >= 5'd15 && op <= 5'd19) v = n ^ c;
         er = (op == 5'd4) ? {8'h00, a} : {8'h00, r};
      end else begin
         case (op)
            5'd21: begin
               r16 = 16'(int'(a) * int'(b));
               c   = r16[7];
               er  = r16;
            end
            5'd22, 5'd23: begin
               if (op == 5'd22) t = int'({a, b}) + int'(w);
               else             t = int'({a, b}) - int'(w);
               r16 = 16'(t);
               c   = (op == 5'd22) ? (t > 65535) : (t < 0);
               v   = (op == 5'd22) ? ((a[7] == w[15]) && (r16[15] != a[7]))
                                   : ((a[7] != w[15]) && (r16[15] != a[7]));
               n   = r16[15];
               z   = (r16 == 16'h0000);
               er  = r16;
            end
            5'd24, 5'd25: begin
               r16 = (op == 5'd24) ? w + 16'd1 : w - 16'd1;
               z   = (r16 == 16'h0000);
               er  = r16;
            end
            default: er = '0;
         endcase
      end
      ec = {cc[7:6], h, cc[4], n, z, v, c};
   endtask

   function automatic logic ref_take(input logic [7:0] cc, input logic [3:0] cond);
      logic n, z, v, c;
      n = cc[3]; z = cc[2]; v = cc[1]; c = cc[0];
      case (cond)
         4'd0:  return 1'b1;
         4'd1:  return 1'b0;
         4'd2:  return !(c || z);
         4'd3:  return c || z;
         4'd4:  return !c;
         4'd5:  return c;
         4'd6:  return !z;
         4'd7:  return z;
         4'd8:  return !v;
         4'd9:  return v;
         4'd10: return !n;
         4'd11: return n;
         4'd12: return !(n ^ v);
         4'd13: return n ^ v;
         4'd14: return !(z || (n ^ v));
         default: return z || (n ^ v);
      endcase
   endfunction

   // drive at a falling edge, the result is registered by the next rising edge
   task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] w, input logic [7:0] cc, input logic [3:0] cond);
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; w_i = w; cc_i = cc; cond_i = cond;
      @(negedge clk);
   endtask

   task automatic run_ref(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [15:0] w, input logic [7:0] cc);
      logic [15:0] er;
      logic [7:0]  ec;
      apply(op, a, b, w, cc, 4'd0);
      ref_model(op, a, b, w, cc, er, ec);
      check(tag_of(op), {16'h0, res_o}, {16'h0, er});
      check(tag_of(op), {24'h0, cc_o}, {24'h0, ec});
   endtask

   localparam logic [7:0] EDGE [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};

   initial begin
      // R14: reset state
      repeat (3) @(negedge clk);
      op_i = OP_COM; a_i = 8'h00; cc_i = 8'hFF; cond_i = 4'd0;
      @(negedge clk);
      check("R14 reset res", {16'h0, res_o}, 32'h0);
      check("R14 reset cc", {24'h0, cc_o}, 32'h0);
      check("R14 reset take", {31'h0, take_o}, 32'h0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].w, VECS[i].cc, 4'd1);
         check(tag_of(VECS[i].op), {16'h0, res_o}, {16'h0, VECS[i].er});
         check(tag_of(VECS[i].op), {24'h0, cc_o}, {24'h0, VECS[i].ec});
      end

      // R14: output holds until the next rising edge
      apply(OP_ADD, 8'h01, 8'h01, 16'h0, 8'hC0, 4'd0);
      op_i = OP_CLR; a_i = 8'h33; cc_i = 8'h00;
      #1;
      check("R14 latency hold", {16'h0, res_o}, 32'h0002);
      @(negedge clk);
      check("R14 latency update", {24'h0, cc_o}, 32'h04);

      // edge-value sweep over every code; R1 via two opposite flag bytes
      for (int op = 0; op < 32; op++) begin
         for (int ia = 0; ia < 4; ia++) begin
            for (int ib = 0; ib < 4; ib++) begin
               for (int k = 0; k < 2; k++) begin
                  logic [7:0] ccv;
                  ccv = (k == 0) ? 8'hC0 : 8'h3F;
                  run_ref(5'(op), EDGE[ia], EDGE[ib], {EDGE[ib], EDGE[ia]}, ccv);
                  check("R1 kept bits", {24'h0, cc_o[7:6], 1'b0, cc_o[4], 4'h0},
                        {24'h0, ccv[7:6], 1'b0, ccv[4], 4'h0});
               end
            end
         end
      end

      // random operands and random incoming flags
      for (int i = 0; i < 600; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         run_ref(5'($urandom_range(0, 31)), rv[7:0], rv[15:8], 16'($urandom), rv[23:16]);
      end

      // R12: every test code against every NZVC pattern, op varied
      for (int cd = 0; cd < 16; cd++) begin
         for (int f = 0; f < 16; f++) begin
            logic [7:0] ccv;
            ccv = {4'($urandom_range(0, 15)), 4'(f)};
            apply(5'($urandom_range(0, 31)), 8'($urandom), 8'($urandom), 16'h0, ccv, 4'(cd));
            check("R12 branch test", {31'h0, take_o}, {31'h0, ref_take(ccv, 4'(cd))});
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule